// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two 18-bit buses, called A and B. The A-to-B path and the B-to-A path are fully separate. Each path has one storage element. A latch-enable control selects between two kinds of operation. With latch enable high, the path passes its input straight through and the storage follows the input. With latch enable low, the path shows its stored word. That word changes only on a rising edge of the path's own clock input, and only while the active-low clock enable is low.

Each path also has an active-low output enable. It controls a drive-enable output only, so the stored contents are never affected by it. The buses appear as separate input, output and drive-enable ports. Any tri-state resolution belongs to the surrounding logic.

The block runs on a system clock. Each path's clock input is sampled on the system clock, and a rising edge is detected when one sample is low and the next sample is high.

Top module: `bus_xcvr18`

## Requirements
- R1: When a path's active-low output enable (`ab_oe_n` or `ba_oe_n`) is 1, that path's drive-enable output (`b_oe` or `a_oe`) is 0, whatever the other controls are. When the output enable is 0, the drive-enable output is 1.
- R2: While latch enable is 1, the path output equals the path input in the same cycle. The path clock and clock enable then have no effect on the output.
- R3: While latch enable is 0 and clock enable is 0, a rising edge of the path clock stores the path input. A rising edge is a system-clock sample of 0 followed by a sample of 1, and the input stored is the one present at the sample of 1. The stored word appears on the output from the next system clock cycle.
- R4: While latch enable is 0 and clock enable is 1, rising edges of the path clock leave the output unchanged.
- R5: While latch enable is 0 and the path clock stays at 0, or stays at 1, the output keeps its previous value.
- R6: When latch enable falls, the path holds the input from the last cycle in which latch enable was 1. A falling edge of the path clock that follows stores nothing.
- R7: The output enable has no effect on storage. While the drive enable is 0, the path output still shows the path value, and captures still take place.
- R8: Reset clears both stored words to zero. A path clock that is already 1 when reset is released does not count as a rising edge.
- R9: The two paths are independent. Controls and data of one path never change the other path's output or stored word.
- R10: The data width is a parameter with a default of 18. Every bit, including an all-ones word, passes through and is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Bus A receive data |
| a_out | output | 18 | Bus A transmit data (B-to-A path) |
| a_oe | output | 1 | Bus A drive enable |
| b_in | input | 18 | Bus B receive data |
| b_out | output | 18 | Bus B transmit data (A-to-B path) |
| b_oe | output | 1 | Bus B drive enable |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_ck | input | 1 | A-to-B path clock |
| ab_cke_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_ck | input | 1 | B-to-A path clock |
| ba_cke_n | input | 1 | B-to-A clock enable, active low |

## Verification
The bench holds the path clock high while latch enable falls, then lowers the clock. A design that captured on the falling edge would replace the held word with whatever data was present at that time. The bench also releases reset with a path clock that is already high. A design that treats that level as an edge would load data into a word that must stay zero. Rising edges are applied with clock enable high, and with the output disabled. Wrong gating would show up either as captures that should not happen or as captures that are lost. The two paths run different patterns in the same cycles, so any coupling between them produces a mismatch on the quiet path.

// File: rtl/bus_xcvr18.sv
module bus_xcvr_path #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         le,
  input  logic         ck,
  input  logic         cke_n,
  output logic [W-1:0] q
);
  logic         ck_q;
  logic [W-1:0] stor;
  logic         rise;

  assign rise = ck & ~ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= 1'b1;
      stor <= '0;
    end else begin
      ck_q <= ck;
      if (le || (rise && !cke_n)) stor <= d;
    end
  end

  assign q = le ? d : stor;
endmodule

module bus_xcvr18 #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ab_cke_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic         ba_cke_n
);
  bus_xcvr_path #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .d(a_in), .le(ab_le),
    .ck(ab_ck), .cke_n(ab_cke_n), .q(b_out)
  );

  bus_xcvr_path #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .d(b_in), .le(ba_le),
    .ck(ba_ck), .cke_n(ba_cke_n), .q(a_out)
  );

  assign b_oe = ~ab_oe_n;
  assign a_oe = ~ba_oe_n;
endmodule

// File: rtl/bus_xcvr18_chk.sv
module bus_xcvr18_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         ab_le,
  input logic         ab_ck,
  input logic         ab_cke_n,
  input logic         ba_le,
  input logic         ba_ck,
  input logic         ba_cke_n
);
  a_r3_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_cke_n && $rose(ab_ck) && $past(rst_n)) |=> (!ab_le -> b_out == $past(a_in)));

  a_r5_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !(!ab_cke_n && $rose(ab_ck) && $past(rst_n))) |=> (!ab_le -> $stable(b_out)));

  a_r6_ab_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |=> (!ab_le -> b_out == $past(a_in)));

  a_r9_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !ba_cke_n && $rose(ba_ck) && $past(rst_n)) |=> (!ba_le -> a_out == $past(b_in)));

  a_r9_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !(!ba_cke_n && $rose(ba_ck) && $past(rst_n))) |=> (!ba_le -> $stable(a_out)));

  a_r9_ba_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le |=> (!ba_le -> a_out == $past(b_in)));
endmodule

bind bus_xcvr18 bus_xcvr18_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .b_in(b_in), .b_out(b_out),
  .ab_le(ab_le), .ab_ck(ab_ck), .ab_cke_n(ab_cke_n),
  .ba_le(ba_le), .ba_ck(ba_ck), .ba_cke_n(ba_cke_n)
);

// File: tb/bus_xcvr18_test.sv
`timescale 1ns/1ps
module bus_xcvr18_test;
  localparam int W = 18;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic ab_oe_n = 1, ab_le = 0, ab_ck = 1, ab_cke_n = 0;
  logic ba_oe_n = 1, ba_le = 0, ba_ck = 0, ba_cke_n = 1;

  int n_cmp = 0, n_bad = 0;
  string req = "R8";
  int m_ab_s = 0, m_ba_s = 0, m_ab_pk = 1, m_ba_pk = 1;

  always #2 clk = ~clk;

  bus_xcvr18 #(.W(W)) uut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ab_s = 0; m_ba_s = 0; m_ab_pk = 1; m_ba_pk = 1;
    end else begin
      if (ab_le == 1) m_ab_s = int'(a_in);
      else if (ab_cke_n == 0 && ab_ck == 1 && m_ab_pk == 0) m_ab_s = int'(a_in);
      if (ba_le == 1) m_ba_s = int'(b_in);
      else if (ba_cke_n == 0 && ba_ck == 1 && m_ba_pk == 0) m_ba_s = int'(b_in);
      m_ab_pk = int'(ab_ck);
      m_ba_pk = int'(ba_ck);
    end
  end

  always @(negedge clk) begin
    int eb, ea;
    eb = ab_le ? int'(a_in) : m_ab_s;
    ea = ba_le ? int'(b_in) : m_ba_s;
    n_cmp++;
    if (int'(b_out) != eb) begin n_bad++; $display("FAIL %s b_out act=%h exp=%h", req, b_out, eb); end
    n_cmp++;
    if (int'(a_out) != ea) begin n_bad++; $display("FAIL %s a_out act=%h exp=%h", req, a_out, ea); end
    n_cmp++;
    if (b_oe != !ab_oe_n) begin n_bad++; $display("FAIL %s b_oe act=%b exp=%b", req, b_oe, !ab_oe_n); end
    n_cmp++;
    if (a_oe != !ba_oe_n) begin n_bad++; $display("FAIL %s a_oe act=%b exp=%b", req, a_oe, !ba_oe_n); end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic ab(input logic oe_n, le, ck, cke_n, input logic [W-1:0] d);
    ab_oe_n = oe_n; ab_le = le; ab_ck = ck; ab_cke_n = cke_n; a_in = d;
  endtask

  task automatic ba(input logic oe_n, le, ck, cke_n, input logic [W-1:0] d);
    ba_oe_n = oe_n; ba_le = le; ba_ck = ck; ba_cke_n = cke_n; b_in = d;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    req = "R8"; a_in = 18'h15A5A; b_in = 18'h2B4B4;
    cyc(3);
    rst_n = 1;
    cyc(4);
    ba(0, 0, 1, 1, 18'h00FF0);
    cyc(3);

    req = "R2";
    for (int i = 0; i < 12; i++) begin
      ab(0, 1, i[0], i[1], W'($urandom));
      cyc();
    end

    req = "R10";
    ab(0, 1, 0, 0, 18'h3FFFF); cyc();
    ab(0, 0, 0, 0, 18'h00000); cyc(2);

    req = "R6";
    ab(0, 1, 1, 0, 18'h12345); cyc();
    ab(0, 0, 1, 0, 18'h0BEEF); cyc(2);
    ab(0, 0, 0, 0, 18'h2AAAA); cyc(3);

    req = "R3";
    for (int i = 0; i < 6; i++) begin
      ab(0, 0, 1, 0, W'($urandom)); cyc();
      ab(0, 0, 1, 0, W'($urandom)); cyc();
      ab(0, 0, 0, 0, W'($urandom)); cyc(2);
    end

    req = "R4";
    for (int i = 0; i < 6; i++) begin
      ab(0, 0, i[0], 1, W'($urandom)); cyc();
    end

    req = "R5";
    ab(0, 0, 0, 0, 18'h01111); cyc(4);
    ab(0, 0, 1, 0, 18'h02222); cyc();
    ab(0, 0, 1, 0, 18'h03333); cyc(4);

    req = "R7";
    ab(1, 0, 0, 0, 18'h04444); cyc();
    ab(1, 0, 1, 0, 18'h05555); cyc();
    ab(1, 0, 1, 0, 18'h06666); cyc(2);
    ab(0, 0, 1, 0, 18'h07777); cyc(2);
    ab(1, 1, 0, 1, 18'h08888); cyc(2);

    req = "R1";
    for (int i = 0; i < 4; i++) begin
      ab(i[0], 0, 0, 1, a_in); ba(i[1], 0, 0, 1, b_in); cyc();
    end

    req = "R9";
    for (int i = 0; i < 20; i++) begin
      ab(0, i % 5 == 0, i[0], i[2], W'($urandom));
      ba(0, i % 7 == 3, i[1], i[3], W'($urandom));
      cyc();
    end
    ba(0, 1, 1, 0, 18'h1C0DE); ab(0, 0, 1, 0, 18'h0F00D); cyc();
    ba(0, 0, 0, 0, 18'h00001); cyc();
    ba(0, 0, 1, 0, 18'h2FACE); ab(0, 0, 0, 0, 18'h13579); cyc(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule